// File: doc/BRIEF.md
# Floating-Point Status and Rounding-Control Unit

This block holds the software-visible floating-point status state of a scalar FPU. The state is one register of sticky exception bits, trap enables and a rounding field. The execution pipeline frames each floating-point operation with two strobes: one when the operation starts and one when it ends. On the start strobe the block clears its per-operation flag accumulator. It also snapshots the rounding field, and that snapshot drives a one-hot rounding-mode output for the whole operation. While the operation is in flight, the raw exception conditions from the arithmetic units are ORed into the accumulator. On the end strobe the gathered conditions fold into the sticky bits.

A sticky bit that moves from clear to set while its trap enable is on produces a one-cycle trap request. A condition whose sticky bit is already set changes nothing and raises no trap. Software reads the register at any time and writes it whole. A write wins over a merge in the same cycle. Sticky bits are cleared only by a write or by reset.

Top module: `fp_status_unit`

## Requirements
- R1: After reset, csrRdData is all zero, roundMode is 4'b0001 and trapReq is 0.
- R2: A cycle with csrWrEn high loads csrWrData into the register, and csrRdData shows it after that clock edge. The register layout is: bits [4:0] sticky flags, bits [9:5] trap enables in the same flag order, bits [11:10] rounding field. The flag order is bit 0 inexact, bit 1 divide-by-zero, bit 2 invalid, bit 3 overflow, bit 4 underflow.
- R3: On opStart the block latches the rounding field, and roundMode then shows it one-hot: field 0 gives bit 0 (nearest-even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward minus infinity) and 3 gives bit 3 (toward plus infinity). A change to the field without an opStart leaves roundMode unchanged.
- R4: On opEnd, every flag present on rawFlags in that cycle sets its sticky bit.
- R5: Flags presented in earlier cycles of the same operation (from the opStart cycle up to opEnd) are also merged at opEnd. Flags presented while no operation is in flight are ignored.
- R6: An opStart while an operation is already in flight discards the flags gathered so far.
- R7: If the merge at opEnd takes a sticky bit from 0 to 1 and that bit's enable is 1, trapReq is high for exactly the cycle after that opEnd edge.
- R8: A merged flag whose sticky bit is already 1 produces no trap. A newly set bit whose enable is 0 becomes set but produces no trap.
- R9: A merge never clears a sticky bit. With no flag gathered, or with no opEnd and no write, the register is unchanged.
- R10: A write in the same cycle as opEnd takes priority: the register takes the written value, the merge is dropped and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | Start strobe of a floating-point operation |
| opEnd | input | 1 | End strobe of a floating-point operation |
| rawFlags | input | 5 | Raw exception conditions, in the flag order of R2 |
| csrWrEn | input | 1 | Software write strobe for the status register |
| csrWrData | input | 12 | Software write value |
| csrRdData | output | 12 | Current status register value |
| roundMode | output | 4 | One-hot rounding mode latched at the last opStart |
| trapReq | output | 1 | One-cycle floating-point trap request |

## Verification
Every result is registered once. A write, a merge, a rounding snapshot or a trap becomes visible on the outputs one clock edge after the cycle that carries its stimulus. Nothing is due later than that. The driver task sets the inputs on the falling edge and pushes the state the requirements predict for the next rising edge. The monitor pops that item 2 ns after the rising edge and compares it there, so every comparison falls in the one cycle in which its result is due. The trap pulse is checked high in that cycle and low in the cycle after it.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int RM_WIDTH = 2;
  localparam int RM_MODES = 1 << RM_WIDTH;
  localparam int EN_LSB = NUM_FLAGS;
  localparam int RM_LSB = 2 * NUM_FLAGS;
  localparam int STAT_WIDTH = RM_LSB + RM_WIDTH;

  typedef struct packed {
    logic swWrite;
    logic merge;
    logic latchMode;
    logic clrAcc;
    logic startAcc;
    logic holdAcc;
  } fpStrobes_t;
endpackage

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opStart,
  input  logic       opEnd,
  input  logic       csrWrEn,
  output fpStrobes_t strobes
);
  logic opActive;

  always_ff @(posedge clk) begin
    if (!rstN) opActive <= 1'b0;
    else if (opEnd) opActive <= 1'b0;
    else if (opStart) opActive <= 1'b1;
  end

  always_comb begin
    strobes.swWrite   = csrWrEn;
    strobes.merge     = opEnd && !csrWrEn;
    strobes.latchMode = opStart;
    strobes.clrAcc    = opEnd;
    strobes.startAcc  = opStart;
    strobes.holdAcc   = opActive;
  end
endmodule

// File: rtl/fp_status_dp.sv
module fp_status_dp
  import fp_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  fpStrobes_t            strobes,
  input  logic [NUM_FLAGS-1:0]  rawFlags,
  input  logic [STAT_WIDTH-1:0] wrData,
  output logic [STAT_WIDTH-1:0] statReg,
  output logic [RM_MODES-1:0]   roundMode,
  output logic                  trapReq
);
  logic [NUM_FLAGS-1:0] accFlags;
  logic [NUM_FLAGS-1:0] mergeVec;
  logic [NUM_FLAGS-1:0] newSet;
  logic [NUM_FLAGS-1:0] stickyNext;
  logic [NUM_FLAGS-1:0] trapHit;
  logic [RM_WIDTH-1:0]  rmLatched;

  wire [NUM_FLAGS-1:0] sticky  = statReg[NUM_FLAGS-1:0];
  wire [NUM_FLAGS-1:0] enables = statReg[EN_LSB +: NUM_FLAGS];

  // gathered flags of this op; a fresh start drops older ones
  assign mergeVec = (strobes.startAcc ? '0 : accFlags) | rawFlags;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign newSet[i]     = mergeVec[i] && !sticky[i];
    assign stickyNext[i] = sticky[i] || mergeVec[i];
    assign trapHit[i]    = newSet[i] && enables[i];
  end

  for (genvar m = 0; m < RM_MODES; m++) begin : g_rm
    assign roundMode[m] = (rmLatched == RM_WIDTH'(m));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg   <= '0;
      rmLatched <= '0;
      accFlags  <= '0;
      trapReq   <= 1'b0;
    end else begin
      if (strobes.swWrite) statReg <= wrData;
      else if (strobes.merge) statReg[NUM_FLAGS-1:0] <= stickyNext;

      trapReq <= strobes.merge && (|trapHit);

      if (strobes.latchMode) rmLatched <= statReg[RM_LSB +: RM_WIDTH];

      if (strobes.clrAcc) accFlags <= '0;
      else if (strobes.startAcc) accFlags <= rawFlags;
      else if (strobes.holdAcc) accFlags <= accFlags | rawFlags;
    end
  end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fp_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opStart,
  input  logic                  opEnd,
  input  logic [NUM_FLAGS-1:0]  rawFlags,
  input  logic                  csrWrEn,
  input  logic [STAT_WIDTH-1:0] csrWrData,
  output logic [STAT_WIDTH-1:0] csrRdData,
  output logic [RM_MODES-1:0]   roundMode,
  output logic                  trapReq
);
  fpStrobes_t strobes;

  fp_status_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opStart (opStart),
    .opEnd   (opEnd),
    .csrWrEn (csrWrEn),
    .strobes (strobes)
  );

  fp_status_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rawFlags  (rawFlags),
    .wrData    (csrWrData),
    .statReg   (csrRdData),
    .roundMode (roundMode),
    .trapReq   (trapReq)
  );
endmodule

// File: rtl/fp_status_checker.sv
module fp_status_checker
  import fp_status_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  opEnd,
  input logic                  csrWrEn,
  input logic [STAT_WIDTH-1:0] csrWrData,
  input logic [STAT_WIDTH-1:0] csrRdData,
  input logic [RM_MODES-1:0]   roundMode,
  input logic                  trapReq
);
  a_r3_mode_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($countones(roundMode) == 1));

  a_r7_trap_after_end: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(opEnd));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(csrWrEn)) |-> (csrRdData == $past(csrWrData)));

  a_r10_no_trap_on_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(csrWrEn)) |-> !trapReq);

  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(csrWrEn)) |->
      ((csrRdData[NUM_FLAGS-1:0] & $past(csrRdData[NUM_FLAGS-1:0])) == $past(csrRdData[NUM_FLAGS-1:0])));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(csrWrEn) && !$past(opEnd)) |-> $stable(csrRdData));
endmodule

bind fp_status_unit fp_status_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opEnd     (opEnd),
  .csrWrEn   (csrWrEn),
  .csrWrData (csrWrData),
  .csrRdData (csrRdData),
  .roundMode (roundMode),
  .trapReq   (trapReq)
);

// File: tb/tb_fp_status_unit.sv
module tb_fp_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opStart = 1'b0;
  logic        opEnd = 1'b0;
  logic [4:0]  rawFlags = '0;
  logic        csrWrEn = 1'b0;
  logic [11:0] csrWrData = '0;
  logic [11:0] csrRdData;
  logic [3:0]  roundMode;
  logic        trapReq;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] st;
    logic [3:0]  rm;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // requirement-level model state
  logic [11:0] mStat = '0;
  logic [1:0]  mRm = '0;
  logic        mActive = 1'b0;
  logic [4:0]  mAcc = '0;

  fp_status_unit dut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opEnd(opEnd),
    .rawFlags(rawFlags), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .roundMode(roundMode), .trapReq(trapReq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      testsFailed++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected < 5000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic drive(input bit os, input bit oe, input logic [4:0] raw,
                       input bit wr, input logic [11:0] wd, input string tag);
    exp_t e;
    logic [4:0] merged;
    logic trap;
    @(negedge clk);
    opStart = os; opEnd = oe; rawFlags = raw; csrWrEn = wr; csrWrData = wd;
    trap = 1'b0;
    merged = (os ? 5'd0 : mAcc) | raw;
    if (os) mRm = mStat[11:10];
    if (wr) mStat = wd;
    else if (oe) begin
      trap = |((merged & ~mStat[4:0]) & mStat[9:5]);
      mStat[4:0] = mStat[4:0] | merged;
    end
    if (oe) mAcc = '0;
    else if (os) mAcc = raw;
    else if (mActive) mAcc = mAcc | raw;
    if (oe) mActive = 1'b0;
    else if (os) mActive = 1'b1;
    e.st = mStat; e.rm = 4'b0001 << mRm; e.trap = trap; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 5'd0, 0, 12'd0, tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      testsRun++;
      if (csrRdData !== e.st || roundMode !== e.rm || trapReq !== e.trap) begin
        testsFailed++;
        $display("FAIL %s: actual st=%h rm=%b trap=%b expected st=%h rm=%b trap=%b",
                 e.tag, csrRdData, roundMode, trapReq, e.st, e.rm, e.trap);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testsRun++;
    if (csrRdData !== 12'd0 || roundMode !== 4'b0001 || trapReq !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: actual st=%h rm=%b trap=%b expected st=000 rm=0001 trap=0",
               csrRdData, roundMode, trapReq);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2: write rm=1, enables inexact+invalid
    drive(0, 0, 5'd0, 1, {2'd1, 5'b00101, 5'b00000}, "R2");
    // R3: snapshot toward-zero, then field change without opStart
    drive(1, 0, 5'd0, 0, 12'd0, "R3");
    drive(0, 0, 5'd0, 1, {2'd3, 5'b00101, 5'b00000}, "R3");
    idle(1, "R3");
    // R9: end with no flags
    drive(0, 1, 5'd0, 0, 12'd0, "R9");
    drive(1, 0, 5'd0, 0, 12'd0, "R3");
    drive(0, 1, 5'd0, 0, 12'd0, "R3");
    drive(0, 0, 5'd0, 1, {2'd2, 5'b00101, 5'b00000}, "R2");
    drive(1, 0, 5'd0, 0, 12'd0, "R3");
    drive(0, 1, 5'd0, 0, 12'd0, "R3");
    // R5: flags while idle are ignored
    drive(0, 0, 5'b11111, 0, 12'd0, "R5");
    drive(0, 0, 5'b11111, 0, 12'd0, "R5");
    drive(1, 0, 5'd0, 0, 12'd0, "R5");
    drive(0, 1, 5'd0, 0, 12'd0, "R5");
    idle(1, "R5");
    // R4/R7: inexact at end, enabled
    drive(1, 0, 5'd0, 0, 12'd0, "R4");
    drive(0, 1, 5'b00001, 0, 12'd0, "R7");
    idle(1, "R7");
    // R8: already set
    drive(1, 0, 5'd0, 0, 12'd0, "R8");
    drive(0, 1, 5'b00001, 0, 12'd0, "R8");
    // R8: overflow with enable off
    drive(1, 0, 5'd0, 0, 12'd0, "R8");
    drive(0, 1, 5'b01000, 0, 12'd0, "R8");
    // R5: divide-by-zero mid op
    drive(1, 0, 5'd0, 0, 12'd0, "R5");
    drive(0, 0, 5'b00010, 0, 12'd0, "R5");
    drive(0, 0, 5'd0, 0, 12'd0, "R5");
    drive(0, 1, 5'd0, 0, 12'd0, "R5");
    // R6: restart discards underflow
    drive(1, 0, 5'd0, 0, 12'd0, "R6");
    drive(0, 0, 5'b10000, 0, 12'd0, "R6");
    drive(1, 0, 5'd0, 0, 12'd0, "R6");
    drive(0, 1, 5'd0, 0, 12'd0, "R6");
    // R10: write with opEnd carrying enabled invalid
    drive(1, 0, 5'd0, 0, 12'd0, "R10");
    drive(0, 1, 5'b00100, 1, {2'd0, 5'b00111, 5'b00000}, "R10");
    idle(1, "R10");
    // R7: invalid now traps, pulse lasts one cycle; R4 with start+end together
    drive(1, 1, 5'b00100, 0, 12'd0, "R7");
    idle(2, "R7");
    // R9: only a write clears sticky bits
    drive(0, 0, 5'd0, 1, {2'd0, 5'b00111, 5'b00000}, "R9");
    drive(1, 0, 5'b00011, 0, 12'd0, "R4");
    drive(0, 1, 5'd0, 0, 12'd0, "R4");
    idle(2, "R4");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule